// File: doc/BRIEF.md
# Indirect Message Bus Access Bridge

This block is a configuration-space slave that gives software a path into a separate internal message bus. Three 32-bit registers are exposed at function zero of bus zero, device zero: a command register, a payload register and an upper-offset register. Software first deposits the payload and, when the target needs them, the upper offset bits. It then writes the command register. That command write is the only access that starts a message-bus transaction.

The command write is non-posted. The bridge holds the configuration port with a wait signal while its request/acknowledge master port is busy, and it releases the write only after the endpoint has acknowledged. For a read command, the returned word is already in the payload register when the write completes, so the next configuration read of that register returns it. Every other opcode is sent as a write-type message, which leaves the payload register untouched.

Top module: `msgbus_bridge`

## Requirements
- R1: After reset, configuration reads of the command, payload and upper-offset registers return 0 and `mb_req` is low.
- R2: A register is selected only when `cfg_bdf` is 0 and `cfg_dw` is 0x34 (command), 0x35 (payload) or 0x36 (upper offset), which are the dword indices of byte offsets D0h, D4h and D8h. Writes to any other index or function are ignored, and reads of them return 0.
- R3: A write to the payload or upper-offset register only stores the value. `mb_req` stays low afterwards.
- R4: A command write raises `mb_req` in the next cycle, for exactly one transaction. In that transaction, `mb_opcode` = command[31:24], `mb_port` = command[23:16] and `mb_be` = command[7:4]. `mb_offset` = {upper[31:8], command[15:8]}, so with upper = 0 the command alone sets the target. `mb_req` falls in the cycle after `mb_ack`.
- R5: `mb_wdata` carries the value most recently stored in the payload register.
- R6: Opcode 0x10 is a read: `mb_read` is 1, and the `mb_rdata` present at acknowledge is loaded into the payload register before the command write completes.
- R7: `cfg_wait` is high from the cycle the command write is presented until the cycle after `mb_ack`, which gives (acknowledge latency + 1) wait cycles. While `mb_req` waits for `mb_ack`, the request fields do not change.
- R8: Every opcode other than 0x10 (including 0x11) gives `mb_read` = 0 and leaves the payload register unchanged.
- R9: Reading the command register returns the last command word written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_req | input | 1 | Configuration access request, held until `cfg_wait` is low |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_bdf | input | 16 | Bus, device and function of the access |
| cfg_dw | input | 10 | Dword index within the function |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| cfg_wait | output | 1 | Stall of the current configuration access |
| mb_req | output | 1 | Message-bus request |
| mb_read | output | 1 | Request expects read-back data |
| mb_opcode | output | 8 | Message opcode |
| mb_port | output | 8 | Target port |
| mb_offset | output | 32 | Target offset |
| mb_be | output | 4 | Byte enables |
| mb_wdata | output | 32 | Write payload |
| mb_ack | input | 1 | Endpoint acknowledge |
| mb_rdata | input | 32 | Endpoint read data, valid with `mb_ack` |

## Verification
A corrupted payload or upper-offset register is visible on `mb_wdata` or `mb_offset` at the very next launched transaction, one cycle after the command write is presented. It also shows on the next configuration read of that register. A sequencer stuck busy or idle shows as a wrong count of `cfg_wait` cycles on the command write, or as a second or missing request. A lost read-back shows as a stale payload on the read that immediately follows the command write.

// File: rtl/msgbus_bridge_pkg.sv
package msgbus_bridge_pkg;
  localparam int REG_W = 32;
  localparam logic [7:0] OP_READ  = 8'h10;
  localparam logic [7:0] OP_WRITE = 8'h11;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} seq_st_e;

  typedef struct packed {
    logic [7:0]       opcode;
    logic [7:0]       port;
    logic [REG_W-1:0] offset;
    logic [3:0]       be;
  } mb_cmd_t;

  // Target assembly: upper offset bits come from the extension word.
  function automatic mb_cmd_t build_cmd(logic [REG_W-1:0] ctrl, logic [REG_W-1:0] ext);
    mb_cmd_t c;
    c.opcode = ctrl[31:24];
    c.port   = ctrl[23:16];
    c.offset = {ext[31:8], ctrl[15:8]};
    c.be     = ctrl[7:4];
    return c;
  endfunction

  function automatic logic is_read_op(logic [7:0] op);
    return op == OP_READ;
  endfunction
endpackage

// File: rtl/msgbus_cfg_decode.sv
module msgbus_cfg_decode #(
  parameter int BDF_W   = 16,
  parameter int DWA_W   = 10,
  parameter int NREG    = 3,
  parameter logic [DWA_W-1:0] BASE_DW = 10'h34
) (
  input  logic             cfg_req,
  input  logic [BDF_W-1:0] cfg_bdf,
  input  logic [DWA_W-1:0] cfg_dw,
  output logic [NREG-1:0]  sel
);
  logic fn_hit;
  assign fn_hit = cfg_req && (cfg_bdf == '0);

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    localparam logic [DWA_W-1:0] IDX = BASE_DW + DWA_W'(i);
    assign sel[i] = fn_hit && (cfg_dw == IDX);
  end
endmodule

// File: rtl/msgbus_regs.sv
module msgbus_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ctrl,
  input  logic         wr_data,
  input  logic         wr_ext,
  input  logic [W-1:0] wval,
  input  logic         rb_load,
  input  logic [W-1:0] rb_val,
  output logic [W-1:0] ctrl_q,
  output logic [W-1:0] data_q,
  output logic [W-1:0] ext_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
      ext_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wval;
      if (wr_ext)  ext_q  <= wval;
      if (rb_load)      data_q <= rb_val;
      else if (wr_data) data_q <= wval;
    end
  end
endmodule

// File: rtl/msgbus_seq.sv
module msgbus_seq
  import msgbus_bridge_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_wr_hit,
  input  logic [W-1:0] ctrl_val,
  input  logic [W-1:0] ext_q,
  input  logic [W-1:0] data_q,
  input  logic         mb_ack,
  input  logic [W-1:0] mb_rdata,
  output logic         launch,
  output logic         hold,
  output logic         rb_load,
  output logic [W-1:0] rb_val,
  output logic         mb_req,
  output logic         mb_read,
  output mb_cmd_t      mb_cmd,
  output logic [W-1:0] mb_wdata
);
  seq_st_e st_q;
  logic    ack_hit;

  assign launch  = ctrl_wr_hit && (st_q == ST_IDLE);
  assign hold    = launch || (st_q == ST_BUSY);
  assign ack_hit = mb_req && mb_ack;
  assign rb_load = ack_hit && mb_read;
  assign rb_val  = mb_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      mb_req   <= 1'b0;
      mb_read  <= 1'b0;
      mb_cmd   <= '0;
      mb_wdata <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (launch) begin
          st_q     <= ST_BUSY;
          mb_req   <= 1'b1;
          mb_cmd   <= build_cmd(ctrl_val, ext_q);
          mb_read  <= is_read_op(ctrl_val[31:24]);
          mb_wdata <= data_q;
        end
        ST_BUSY: if (ack_hit) begin
          st_q   <= ST_DONE;
          mb_req <= 1'b0;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msgbus_bridge.sv
module msgbus_bridge
  import msgbus_bridge_pkg::*;
#(
  parameter int BDF_W = 16,
  parameter int DWA_W = 10,
  parameter logic [DWA_W-1:0] BASE_DW = 10'h34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_req,
  input  logic             cfg_we,
  input  logic [BDF_W-1:0] cfg_bdf,
  input  logic [DWA_W-1:0] cfg_dw,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic             cfg_wait,
  output logic             mb_req,
  output logic             mb_read,
  output logic [7:0]       mb_opcode,
  output logic [7:0]       mb_port,
  output logic [31:0]      mb_offset,
  output logic [3:0]       mb_be,
  output logic [31:0]      mb_wdata,
  input  logic             mb_ack,
  input  logic [31:0]      mb_rdata
);
  localparam int NREG = 3;
  localparam int I_CTRL = 0;
  localparam int I_DATA = 1;
  localparam int I_EXT  = 2;

  logic [NREG-1:0] sel;
  logic [31:0]     ctrl_q, data_q, ext_q, rb_val;
  logic            accept, ev_launch, ev_store, rb_load;
  mb_cmd_t         cmd;

  msgbus_cfg_decode #(.BDF_W(BDF_W), .DWA_W(DWA_W), .NREG(NREG), .BASE_DW(BASE_DW)) u_dec (
    .cfg_req(cfg_req), .cfg_bdf(cfg_bdf), .cfg_dw(cfg_dw), .sel(sel)
  );

  assign accept   = cfg_req && !cfg_wait;
  assign ev_store = accept && cfg_we && (sel[I_DATA] || sel[I_EXT]);

  msgbus_regs #(.W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(ev_launch),
    .wr_data(accept && cfg_we && sel[I_DATA]),
    .wr_ext(accept && cfg_we && sel[I_EXT]),
    .wval(cfg_wdata), .rb_load(rb_load), .rb_val(rb_val),
    .ctrl_q(ctrl_q), .data_q(data_q), .ext_q(ext_q)
  );

  msgbus_seq #(.W(REG_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr_hit(cfg_we && sel[I_CTRL]), .ctrl_val(cfg_wdata),
    .ext_q(ext_q), .data_q(data_q),
    .mb_ack(mb_ack), .mb_rdata(mb_rdata),
    .launch(ev_launch), .hold(cfg_wait), .rb_load(rb_load), .rb_val(rb_val),
    .mb_req(mb_req), .mb_read(mb_read), .mb_cmd(cmd), .mb_wdata(mb_wdata)
  );

  assign mb_opcode = cmd.opcode;
  assign mb_port   = cmd.port;
  assign mb_offset = cmd.offset;
  assign mb_be     = cmd.be;

  always_comb begin
    cfg_rdata = '0;
    if (sel[I_CTRL])     cfg_rdata = ctrl_q;
    else if (sel[I_DATA]) cfg_rdata = data_q;
    else if (sel[I_EXT])  cfg_rdata = ext_q;
  end
endmodule

// File: rtl/msgbus_bridge_chk.sv
module msgbus_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wait,
  input logic        mb_req,
  input logic        mb_ack,
  input logic        mb_read,
  input logic [7:0]  mb_opcode,
  input logic [31:0] mb_offset,
  input logic [31:0] mb_wdata,
  input logic [31:0] mb_rdata,
  input logic        ev_launch,
  input logic        ev_store,
  input logic [31:0] data_q
);
  p_launch_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_launch |=> mb_req);
  p_single_txn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_req && mb_ack) |=> !mb_req);
  p_store_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_store && !mb_req) |=> !mb_req);
  p_req_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req |-> cfg_wait);
  p_req_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_req && !mb_ack) |=> (mb_req && $stable(mb_offset) && $stable(mb_opcode) && $stable(mb_wdata)));
  p_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_req && mb_ack && mb_read) |=> (data_q == $past(mb_rdata)));
  p_no_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_req && mb_ack && !mb_read) |=> $stable(data_q));
  p_read_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req |-> (mb_read == (mb_opcode == 8'h10)));
endmodule

bind msgbus_bridge msgbus_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .mb_req(mb_req), .mb_ack(mb_ack),
  .mb_read(mb_read), .mb_opcode(mb_opcode), .mb_offset(mb_offset), .mb_wdata(mb_wdata),
  .mb_rdata(mb_rdata), .ev_launch(ev_launch), .ev_store(ev_store), .data_q(data_q)
);

// File: tb/msgbus_bridge_bench.sv
module msgbus_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam logic [9:0] DW_CTRL = 10'h34, DW_DATA = 10'h35, DW_EXT = 10'h36;

  // vector table: ext, payload, command, endpoint response, ack latency, expected offset, payload after
  localparam logic [31:0] V_EXT [NV] = '{32'h0000_0000, 32'h1234_5600, 32'hFFFF_FF00, 32'h0000_0100};
  localparam logic [31:0] V_DAT [NV] = '{32'hA5A5_0001, 32'h0BAD_F00D, 32'h1111_2222, 32'h0000_0000};
  localparam logic [31:0] V_CMD [NV] = '{32'h1105_3CF0, 32'h1022_8030, 32'h07FF_0110, 32'h1001_FFF0};
  localparam logic [31:0] V_RSP [NV] = '{32'hDEAD_0000, 32'hCAFE_BABE, 32'h5555_5555, 32'h0000_0001};
  localparam int          V_LAT [NV] = '{1, 3, 2, 5};
  localparam logic [31:0] V_OFS [NV] = '{32'h0000_003C, 32'h1234_5680, 32'hFFFF_FF01, 32'h0000_01FF};
  localparam logic [31:0] V_AFT [NV] = '{32'hA5A5_0001, 32'hCAFE_BABE, 32'h1111_2222, 32'h0000_0001};
  localparam logic        V_RD  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 0, rst_n = 0;
  logic cfg_req = 0, cfg_we = 0;
  logic [15:0] cfg_bdf = '0;
  logic [9:0]  cfg_dw = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic cfg_wait, mb_req, mb_read, mb_ack = 0;
  logic [7:0] mb_opcode, mb_port;
  logic [31:0] mb_offset, mb_wdata, mb_rdata = '0;
  logic [3:0] mb_be;

  int errors = 0, checks = 0;
  int ep_lat = 1, ep_cnt = 0, txn_count = 0;
  logic [31:0] ep_rsp = '0, cap_ofs, cap_wd;
  logic [7:0] cap_op, cap_port;
  logic [3:0] cap_be;
  logic cap_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  msgbus_bridge u_msgbus_bridge (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bdf(cfg_bdf),
    .cfg_dw(cfg_dw), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_wait(cfg_wait),
    .mb_req(mb_req), .mb_read(mb_read), .mb_opcode(mb_opcode), .mb_port(mb_port),
    .mb_offset(mb_offset), .mb_be(mb_be), .mb_wdata(mb_wdata), .mb_ack(mb_ack), .mb_rdata(mb_rdata)
  );

  // endpoint model: acknowledge after ep_lat cycles of request
  always @(negedge clk) begin
    if (mb_req && !mb_ack) begin
      ep_cnt = ep_cnt + 1;
      if (ep_cnt == ep_lat) begin
        mb_ack = 1; mb_rdata = ep_rsp; txn_count++;
        cap_op = mb_opcode; cap_port = mb_port; cap_ofs = mb_offset;
        cap_be = mb_be; cap_wd = mb_wdata; cap_rd = mb_read;
      end
    end else begin
      mb_ack = 0; ep_cnt = 0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [15:0] bdf, logic [9:0] dw, logic [31:0] val, output int waits);
    @(negedge clk);
    cfg_req = 1; cfg_we = 1; cfg_bdf = bdf; cfg_dw = dw; cfg_wdata = val;
    waits = 0;
    #1;
    while (cfg_wait) begin @(negedge clk); #1; waits++; end
    @(negedge clk);
    cfg_req = 0; cfg_we = 0;
  endtask

  task automatic cfg_read(logic [15:0] bdf, logic [9:0] dw, output logic [31:0] val);
    @(negedge clk);
    cfg_req = 1; cfg_we = 0; cfg_bdf = bdf; cfg_dw = dw;
    #1;
    while (cfg_wait) begin @(negedge clk); #1; end
    val = cfg_rdata;
    @(negedge clk);
    cfg_req = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int w, t0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 req", {31'b0, mb_req}, 0);
    cfg_read(0, DW_CTRL, rv); check("R1 ctrl", rv, 0);
    cfg_read(0, DW_DATA, rv); check("R1 data", rv, 0);
    cfg_read(0, DW_EXT, rv);  check("R1 ext", rv, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      ep_lat = V_LAT[i]; ep_rsp = V_RSP[i];
      t0 = txn_count;
      cfg_write(0, DW_EXT, V_EXT[i], w);
      cfg_write(0, DW_DATA, V_DAT[i], w);
      @(negedge clk);
      check("R3 no txn on store", txn_count - t0, 0);
      check("R3 req low", {31'b0, mb_req}, 0);
      cfg_write(0, DW_CTRL, V_CMD[i], w);
      check("R4 one txn", txn_count - t0, 1);
      check("R4 opcode", {24'b0, cap_op}, {24'b0, V_CMD[i][31:24]});
      check("R4 port", {24'b0, cap_port}, {24'b0, V_CMD[i][23:16]});
      check("R4 be", {28'b0, cap_be}, {28'b0, V_CMD[i][7:4]});
      check("R4 offset", cap_ofs, V_OFS[i]);
      check("R5 wdata", cap_wd, V_DAT[i]);
      check("R7 wait cycles", w, V_LAT[i] + 1);
      check(V_RD[i] ? "R6 read flag" : "R8 read flag", {31'b0, cap_rd}, {31'b0, V_RD[i]});
      cfg_read(0, DW_DATA, rv);
      check(V_RD[i] ? "R6 payload loaded" : "R8 payload kept", rv, V_AFT[i]);
      cfg_read(0, DW_CTRL, rv); check("R9 ctrl readback", rv, V_CMD[i]);
      cfg_read(0, DW_EXT, rv);  check("R2 ext readback", rv, V_EXT[i]);
      @(negedge clk);
      check("R4 req dropped", {31'b0, mb_req}, 0);
    end

    // R2: misses are ignored and read 0
    t0 = txn_count;
    cfg_write(0, 10'h37, 32'h9999_9999, w);
    cfg_write(16'h0001, DW_DATA, 32'h7777_7777, w);
    cfg_write(16'h0008, DW_CTRL, 32'h1100_0000, w);
    cfg_read(0, DW_DATA, rv); check("R2 payload unchanged", rv, V_AFT[NV-1]);
    cfg_read(0, 10'h37, rv); check("R2 miss reads 0", rv, 0);
    cfg_read(16'h0001, DW_EXT, rv); check("R2 other function reads 0", rv, 0);
    check("R2 no txn on miss", txn_count - t0, 0);

    // R8 with opcode 0x11 after a read; R5 uses latest payload
    ep_lat = 1; ep_rsp = 32'hFEED_FACE;
    cfg_write(0, DW_DATA, 32'h0102_0304, w);
    cfg_write(0, DW_DATA, 32'h0506_0708, w);
    cfg_write(0, DW_CTRL, 32'h1100_0000, w);
    check("R5 latest payload", cap_wd, 32'h0506_0708);
    cfg_read(0, DW_DATA, rv); check("R8 write op keeps payload", rv, 32'h0506_0708);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule